// File: doc/BRIEF.md
# Colour Map Block Transfer Controller

This block moves a run of 32-bit entries from a staging memory into one of the live lookup tables that feed the display DAC. Software first fills the staging memory, loads a source word address into a source register, and then writes one control word. That word names the target table (main colour map, cursor colours or overlay map), the first destination entry, and how many entries to copy. It can also ask for the copy to be held back until vertical blanking begins, so a palette change never lands in the middle of a visible frame.

The staging memory sits outside the block and answers a read one cycle after it is asked. The live tables also sit outside the block and accept one write per cycle on the table write port. Each entry takes two cycles: a fetch cycle that issues the staging read, then a store cycle that drives the table write. A busy flag covers the whole transfer, including the time spent waiting for blanking. While the flag is high, new control words and source writes are dropped.

The sequencer has four states. In ST_IDLE it waits for a control word. An accepted word moves it to ST_FETCH, or to ST_ARMED when the word asks to wait for blanking. ST_ARMED moves to ST_FETCH when a blank begins. ST_FETCH always moves to ST_STORE. ST_STORE goes back to ST_FETCH while entries remain, and returns to ST_IDLE after the last one.

Top module: `cmap_xfer_ctrl`

## Requirements
- R1: After reset, busy is 0 and no table write is issued.
- R2: A control word is accepted only when all of these hold: the block is idle, bit 31 is 1, bits 15:14 are not 01, and the length in bits 9:0 is non-zero. In every other case the word is ignored: busy stays 0 and no table write happens.
- R3: Bits 15:14 of the control word pick the target table: 00 is the main colour map, 10 is the cursor colours and 11 is the overlay map. The same 2-bit code appears on lut_tgt with every write of that transfer.
- R4: For entry i, counting from 0 up to length-1, the block reads staging address (source + i) and writes table address (offset + i). The offset sits in bits 25:16 of the control word and the source in the source register. Entries are written in increasing order of i.
- R5: lut_data carries bits 23:0 of the staging word, the RGB value. The top byte is dropped.
- R6: For the cursor-colour target the table address is (offset + i) modulo 4, so a run that starts at entry 2 with length 4 writes entries 2, 3, 0, 1.
- R7: When bit 30 is set, no entry is written until the first 0-to-1 change of vblank that is seen in a cycle after the control cycle. A blank already in progress does not start the copy, and neither does a blank that begins in the same cycle as the control word.
- R8: Without bit 30, busy is 1 in the first cycle after the control cycle and lut_we is 0 there. The first write appears in the second cycle, and after that one write appears every two cycles. busy drops in the cycle after the last write.
- R9: A control word that arrives while busy is 1 is ignored. This includes the cycle of the last write. It starts no further transfer.
- R10: A source register write while busy is 1 is ignored. The source register keeps its value from one transfer to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 32 | Control word |
| src_we | input | 1 | Source register write strobe |
| src_data | input | 12 | Source staging word address |
| vblank | input | 1 | Vertical blanking level from the display timing |
| stg_rd_en | output | 1 | Staging memory read request |
| stg_rd_addr | output | 12 | Staging memory word address |
| stg_rd_data | input | 32 | Staging word returned one cycle after the request |
| busy | output | 1 | Transfer accepted and not yet finished |
| lut_we | output | 1 | Live table write strobe |
| lut_tgt | output | 2 | Target table code for this write |
| lut_addr | output | 10 | Live table entry address |
| lut_data | output | 24 | RGB value to write |

## Verification
Two things can collide with the copy sequencer. The first is a control word that lands in the same cycle as the final store. The bench watches the table port and drives a fresh, valid word exactly when the last entry's write is visible. It then requires busy to fall and stay low, with no extra write reaching the scoreboard. The second is a blank that begins in the same cycle as a wait-for-blank control word. The bench raises vblank together with the strobe and requires no write until vblank has fallen and risen again. All expected writes go through a queue, and the monitor compares target, address and data for every write.

// File: rtl/cmap_xfer_pkg.sv
package cmap_xfer_pkg;

    typedef enum logic [1:0] {
        TGT_CMAP = 2'b00,
        TGT_RSVD = 2'b01,
        TGT_CURS = 2'b10,
        TGT_OVLY = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_STORE
    } st_e;

    localparam int CTL_EN_BIT   = 31;
    localparam int CTL_WAIT_BIT = 30;
    localparam int CTL_OFFS_LSB = 16;
    localparam int CTL_TGT_LSB  = 14;
    localparam int CURS_ENTRIES = 4;
    localparam int RGB_W        = 24;

endpackage

// File: rtl/cmap_ctl_decode.sv
module cmap_ctl_decode
    import cmap_xfer_pkg::*;
#(
    parameter int LUT_AW = 10,
    parameter int LEN_W  = 10
) (
    input  logic [31:0]       ctl_word,
    output logic              go,
    output logic              wait_blank,
    output tgt_e              tgt,
    output logic [LUT_AW-1:0] offs,
    output logic [LEN_W-1:0]  len
);

    localparam int OFFS_MSB = CTL_OFFS_LSB + LUT_AW - 1;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_word[CTL_WAIT_BIT-1:OFFS_MSB+1],
                               ctl_word[CTL_TGT_LSB-1:LEN_W]};

    always_comb begin
        tgt        = tgt_e'(ctl_word[CTL_TGT_LSB +: 2]);
        offs       = ctl_word[CTL_OFFS_LSB +: LUT_AW];
        len        = ctl_word[LEN_W-1:0];
        wait_blank = ctl_word[CTL_WAIT_BIT];
        go         = ctl_word[CTL_EN_BIT] && (tgt != TGT_RSVD) && (len != '0);
    end

endmodule

// File: rtl/cmap_blank_sync.sv
module cmap_blank_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    output logic blank_start
);

    logic vblank_q;

    always_ff @(posedge clk) begin
        if (!rst_n) vblank_q <= 1'b0;
        else        vblank_q <= vblank;
    end

    assign blank_start = vblank && !vblank_q;

endmodule

// File: rtl/cmap_xfer_seq.sv
module cmap_xfer_seq
    import cmap_xfer_pkg::*;
#(
    parameter int SRC_AW = 12,
    parameter int LUT_AW = 10,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              go,
    input  logic              wait_blank,
    input  tgt_e              tgt,
    input  logic [LUT_AW-1:0] offs,
    input  logic [LEN_W-1:0]  len,
    input  logic              src_we,
    input  logic [SRC_AW-1:0] src_data,
    input  logic              blank_start,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              rd_en,
    output logic [SRC_AW-1:0] rd_addr,
    output logic              lut_we,
    output tgt_e              lut_tgt,
    output logic [LUT_AW-1:0] lut_addr,
    output logic [RGB_W-1:0]  lut_data
);

    localparam int CURS_AW = $clog2(CURS_ENTRIES);

    st_e               state, state_nx;
    logic [SRC_AW-1:0] src_q;
    logic [LUT_AW-1:0] dst_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    tgt_e              tgt_q;
    logic              accept;
    logic              last;
    logic [LUT_AW-1:0] dst_lin;

    logic unused_top_byte;
    assign unused_top_byte = ^rd_data[31:RGB_W];

    assign accept  = ctl_we && go && (state == ST_IDLE);
    assign last    = (idx_q == len_q - LEN_W'(1));
    assign dst_lin = dst_q + LUT_AW'(idx_q);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = wait_blank ? ST_ARMED : ST_FETCH;
            ST_ARMED: if (blank_start) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_STORE;
            ST_STORE: state_nx = last ? ST_IDLE : ST_FETCH;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transfer parameters and entry counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            idx_q <= '0;
            tgt_q <= TGT_CMAP;
        end else begin
            if (src_we && state == ST_IDLE) src_q <= src_data;
            if (accept) begin
                dst_q <= offs;
                len_q <= len;
                tgt_q <= tgt;
                idx_q <= '0;
            end else if (state == ST_STORE) begin
                idx_q <= idx_q + LEN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b0;
        rd_en    = 1'b0;
        lut_we   = 1'b0;
        rd_addr  = src_q + SRC_AW'(idx_q);
        lut_tgt  = tgt_q;
        lut_data = rd_data[RGB_W-1:0];
        lut_addr = (tgt_q == TGT_CURS) ? LUT_AW'(dst_lin[CURS_AW-1:0]) : dst_lin;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_ARMED: busy = 1'b1;
            ST_FETCH: begin busy = 1'b1; rd_en  = 1'b1; end
            ST_STORE: begin busy = 1'b1; lut_we = 1'b1; end
            default:  busy = 1'b0;
        endcase
    end

    // R7: an armed transfer holds until a blank begins
    a_r7_hold_until_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !blank_start) |=> (state == ST_ARMED && !lut_we));

    // R8: every staging read is followed by a table write
    a_r8_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> lut_we);

    // R8: busy only drops right after a table write
    a_r8_busy_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(lut_we));

    // R6: cursor writes stay in the four-entry table
    a_r6_cursor_range: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_we && lut_tgt == TGT_CURS) |-> (lut_addr < LUT_AW'(CURS_ENTRIES)));

    // R2: the reserved code never reaches the table port
    a_r2_no_reserved_target: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |-> (lut_tgt != TGT_RSVD));

    // R9: table parameters are frozen while busy
    a_r9_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_we) |=> ($stable(len_q) && $stable(dst_q)));

    // R10: the source register does not move during a transfer
    a_r10_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && src_we) |=> $stable(src_q));

endmodule

// File: rtl/cmap_xfer_ctrl.sv
module cmap_xfer_ctrl
    import cmap_xfer_pkg::*;
#(
    parameter int SRC_AW = 12,
    parameter int LUT_AW = 10,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_data,
    input  logic              src_we,
    input  logic [SRC_AW-1:0] src_data,
    input  logic              vblank,
    output logic              stg_rd_en,
    output logic [SRC_AW-1:0] stg_rd_addr,
    input  logic [31:0]       stg_rd_data,
    output logic              busy,
    output logic              lut_we,
    output logic [1:0]        lut_tgt,
    output logic [LUT_AW-1:0] lut_addr,
    output logic [RGB_W-1:0]  lut_data
);

    logic              go;
    logic              wait_blank;
    tgt_e              dec_tgt;
    tgt_e              wr_tgt;
    logic [LUT_AW-1:0] dec_offs;
    logic [LEN_W-1:0]  dec_len;
    logic              blank_start;

    cmap_ctl_decode #(.LUT_AW(LUT_AW), .LEN_W(LEN_W)) u_dec (
        .ctl_word   (ctl_data),
        .go         (go),
        .wait_blank (wait_blank),
        .tgt        (dec_tgt),
        .offs       (dec_offs),
        .len        (dec_len)
    );

    cmap_blank_sync u_blank (
        .clk         (clk),
        .rst_n       (rst_n),
        .vblank      (vblank),
        .blank_start (blank_start)
    );

    cmap_xfer_seq #(.SRC_AW(SRC_AW), .LUT_AW(LUT_AW), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .go          (go),
        .wait_blank  (wait_blank),
        .tgt         (dec_tgt),
        .offs        (dec_offs),
        .len         (dec_len),
        .src_we      (src_we),
        .src_data    (src_data),
        .blank_start (blank_start),
        .rd_data     (stg_rd_data),
        .busy        (busy),
        .rd_en       (stg_rd_en),
        .rd_addr     (stg_rd_addr),
        .lut_we      (lut_we),
        .lut_tgt     (wr_tgt),
        .lut_addr    (lut_addr),
        .lut_data    (lut_data)
    );

    assign lut_tgt = wr_tgt;

    // R2: busy only rises after a control write
    a_r2_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_we));

    // R1: nothing is written while idle
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lut_we);

endmodule

// File: tb/tb_cmap_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_cmap_xfer_ctrl;

    typedef struct packed {
        logic [1:0]  tgt;
        logic [9:0]  addr;
        logic [23:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        src_we = 1'b0;
    logic [11:0] src_data = '0;
    logic        vblank = 1'b0;
    logic        stg_rd_en;
    logic [11:0] stg_rd_addr;
    logic [31:0] stg_rd_data = '0;
    logic        busy;
    logic        lut_we;
    logic [1:0]  lut_tgt;
    logic [9:0]  lut_addr;
    logic [23:0] lut_data;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   wr_cnt   = 0;
    bit   done     = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    cmap_xfer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .src_we(src_we), .src_data(src_data), .vblank(vblank),
        .stg_rd_en(stg_rd_en), .stg_rd_addr(stg_rd_addr), .stg_rd_data(stg_rd_data),
        .busy(busy), .lut_we(lut_we), .lut_tgt(lut_tgt),
        .lut_addr(lut_addr), .lut_data(lut_data)
    );

    function automatic logic [31:0] stg_word(input logic [11:0] a);
        logic [7:0] b;
        b = a[7:0];
        return {b ^ 8'h5A, b + 8'h03, ~b, a[11:8] ^ b[7:4], b[3:0]};
    endfunction

    // staging memory model: one-cycle read
    always @(posedge clk) if (stg_rd_en) stg_rd_data <= stg_word(stg_rd_addr);

    function automatic logic [31:0] mkctl(input bit en, input bit wt, input logic [1:0] tgt,
                                          input int off, input int len);
        logic [9:0] o;
        logic [9:0] l;
        o = off[9:0];
        l = len[9:0];
        return {en, wt, 4'b0, o, tgt, 4'b0, l};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_xfer(input logic [1:0] tgt, input int off, input int len, input int src);
        for (int i = 0; i < len; i++) begin
            exp_t e;
            int   a;
            a = (off + i) & 1023;
            if (tgt == 2'b10) a = a & 3;
            e.tgt  = tgt;
            e.addr = a[9:0];
            e.data = stg_word(12'((src + i) & 4095))[23:0];
            q.push_back(e);
        end
    endtask

    task automatic send_ctl(input logic [31:0] w);
        @(negedge clk);
        ctl_we   = 1'b1;
        ctl_data = w;
        @(negedge clk);
        ctl_we   = 1'b0;
    endtask

    task automatic set_src(input int s);
        @(negedge clk);
        src_we   = 1'b1;
        src_data = s[11:0];
        @(negedge clk);
        src_we   = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, tag, 32'(busy), 32'h0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && lut_we) begin
            wr_cnt++;
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected table write", 32'(lut_addr), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(lut_tgt == e.tgt, "R3 target code", 32'(lut_tgt), 32'(e.tgt));
                chk(lut_addr == e.addr, "R4 R6 table address", 32'(lut_addr), 32'(e.addr));
                chk(lut_data == e.data, "R5 rgb data", 32'(lut_data), 32'(e.data));
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            finish_run();
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'h0);
        chk(lut_we == 1'b0, "R1 no write after reset", 32'(lut_we), 32'h0);

        // R4 R8: full main map from source 0, timing of the first entry
        set_src(0);
        base = wr_cnt;
        push_xfer(2'b00, 0, 256, 0);
        send_ctl(mkctl(1, 0, 2'b00, 0, 256));
        chk(busy == 1'b1, "R8 busy one cycle after control", 32'(busy), 32'h1);
        chk(lut_we == 1'b0, "R8 no write one cycle after control", 32'(lut_we), 32'h0);
        @(negedge clk);
        chk(lut_we == 1'b1, "R8 first write two cycles after control", 32'(lut_we), 32'h1);
        wait_idle("R8 full map finishes");
        chk(wr_cnt - base == 256, "R4 full map entry count", 32'(wr_cnt - base), 32'd256);

        // R3 R4: overlay run at offset 512 from source 7
        set_src(7);
        base = wr_cnt;
        push_xfer(2'b11, 512, 3, 7);
        send_ctl(mkctl(1, 0, 2'b11, 512, 3));
        wait_idle("R3 overlay finishes");
        chk(wr_cnt - base == 3, "R4 overlay count", 32'(wr_cnt - base), 32'd3);

        // R6: cursor colours wrap modulo 4
        base = wr_cnt;
        push_xfer(2'b10, 2, 4, 7);
        send_ctl(mkctl(1, 0, 2'b10, 2, 4));
        wait_idle("R6 cursor finishes");
        chk(wr_cnt - base == 4, "R6 cursor count", 32'(wr_cnt - base), 32'd4);

        // R2: ignored control words
        base = wr_cnt;
        send_ctl(mkctl(0, 0, 2'b00, 0, 8));
        chk(busy == 1'b0, "R2 enable clear ignored", 32'(busy), 32'h0);
        send_ctl(mkctl(1, 0, 2'b01, 0, 8));
        chk(busy == 1'b0, "R2 reserved target ignored", 32'(busy), 32'h0);
        send_ctl(mkctl(1, 0, 2'b00, 0, 0));
        chk(busy == 1'b0, "R2 zero length ignored", 32'(busy), 32'h0);
        repeat (4) @(negedge clk);
        chk(wr_cnt == base, "R2 no writes from ignored words", 32'(wr_cnt - base), 32'h0);

        // R7: wait for a blank to begin
        vblank = 1'b0;
        base = wr_cnt;
        push_xfer(2'b00, 300, 5, 7);
        send_ctl(mkctl(1, 1, 2'b00, 300, 5));
        repeat (10) @(negedge clk);
        chk(busy == 1'b1, "R7 busy while armed", 32'(busy), 32'h1);
        chk(wr_cnt == base, "R7 no write before blank", 32'(wr_cnt - base), 32'h0);
        vblank = 1'b1;
        @(negedge clk);
        wait_idle("R7 armed transfer finishes");
        chk(wr_cnt - base == 5, "R7 count after blank", 32'(wr_cnt - base), 32'd5);

        // R7: blank starting in the control cycle does not count
        vblank = 1'b0;
        repeat (2) @(negedge clk);
        base = wr_cnt;
        push_xfer(2'b11, 700, 2, 7);
        ctl_we = 1'b1;
        ctl_data = mkctl(1, 1, 2'b11, 700, 2);
        vblank = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (6) @(negedge clk);
        chk(wr_cnt == base, "R7 coincident blank ignored", 32'(wr_cnt - base), 32'h0);
        chk(busy == 1'b1, "R7 still armed during blank", 32'(busy), 32'h1);
        vblank = 1'b0;
        repeat (3) @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        wait_idle("R7 second blank finishes");
        chk(wr_cnt - base == 2, "R7 count after next blank", 32'(wr_cnt - base), 32'd2);
        vblank = 1'b0;

        // R9: control write in the middle of a transfer
        base = wr_cnt;
        push_xfer(2'b00, 100, 5, 7);
        send_ctl(mkctl(1, 0, 2'b00, 100, 5));
        @(negedge clk);
        send_ctl(mkctl(1, 0, 2'b11, 900, 7));
        wait_idle("R9 first transfer finishes");
        repeat (4) @(negedge clk);
        chk(wr_cnt - base == 5, "R9 mid-transfer word ignored", 32'(wr_cnt - base), 32'd5);

        // R9: control write in the cycle of the last write
        base = wr_cnt;
        push_xfer(2'b11, 20, 2, 7);
        send_ctl(mkctl(1, 0, 2'b11, 20, 2));
        while (!(lut_we && lut_addr == 10'd21)) @(negedge clk);
        ctl_we = 1'b1;
        ctl_data = mkctl(1, 0, 2'b00, 60, 3);
        @(negedge clk);
        ctl_we = 1'b0;
        chk(busy == 1'b0, "R9 busy falls after last write", 32'(busy), 32'h0);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R9 last-cycle word ignored", 32'(busy), 32'h0);
        chk(wr_cnt - base == 2, "R9 last-cycle count", 32'(wr_cnt - base), 32'd2);

        // R10: source write while busy is ignored and source persists
        push_xfer(2'b00, 40, 6, 7);
        send_ctl(mkctl(1, 0, 2'b00, 40, 6));
        set_src(300);
        wait_idle("R10 transfer finishes");
        base = wr_cnt;
        push_xfer(2'b00, 50, 2, 7);
        send_ctl(mkctl(1, 0, 2'b00, 50, 2));
        wait_idle("R10 follow-up finishes");
        chk(wr_cnt - base == 2, "R10 follow-up count", 32'(wr_cnt - base), 32'd2);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R4 scoreboard drained", 32'(q.size()), 32'h0);
        done = 1;
        finish_run();
    end

endmodule